// File: doc/BRIEF.md
# Early-Terminating Iterative Multiplier

This block multiplies two 32-bit operands over several clock cycles and returns the low 32 bits of the product. The multiplier operand is taken one byte per cycle, starting with the least significant byte. Each cycle adds the multiplicand times that byte into an accumulator at the byte's weight. The run stops as soon as every bit above the bytes already used is a copy of one value, either all zeros or all ones. A result then takes one to four cycles, and small multipliers of either sign finish quickly.

A caller raises `start` for one cycle with the operands and the incoming carry and overflow flags. The block answers with `busy` while it works and a one-cycle `done` pulse when the result is ready. With the result it returns the negative and zero flags of the product, the carry and overflow flags unchanged, and the number of cycles it took.

Top module: `iter_mul`

## Requirements
- R1: While reset is held and right after it, `busy`, `done`, `product`, `flagN`, `flagZ`, `carryOut`, `ovfOut` and `arrayCycles` are all zero.
- R2: When `start` is high at a rising edge while `busy` is low, the block captures both operands and `busy` is high after that edge. Operand changes after that edge do not affect the result.
- R3: `arrayCycles` reports the cycle count m, with the multiplier read as a signed 32-bit value. m is 1 inside [-256, 255], 2 inside [-65536, 65535] but not the first range, 3 inside [-2^24, 2^24-1] but not the earlier ranges, and 4 otherwise.
- R4: `done` is high for exactly one cycle, after the m-th rising edge following the accepted start edge. At that point `busy` is low.
- R5: When `done` is high, `product` equals the low 32 bits of multiplicand times multiplier. The value is the same whether both operands are read as signed or as unsigned.
- R6: When `done` is high, `flagN` equals bit 31 of `product` and `flagZ` is 1 exactly when `product` is zero.
- R7: `carryOut` and `ovfOut` equal `carryIn` and `ovfIn` as sampled at the accepted start edge.
- R8: A `start` pulse while `busy` is high is ignored. The running result, count and flags stay those of the operation already in progress.
- R9: After `done`, `product`, the flags and `arrayCycles` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| multiplicand | input | 32 | First operand |
| multiplier | input | 32 | Operand consumed byte by byte; sets the cycle count |
| carryIn | input | 1 | Carry flag to pass through |
| ovfIn | input | 1 | Overflow flag to pass through |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-ready pulse |
| product | output | 32 | Low 32 bits of the product |
| flagN | output | 1 | Negative flag of the result |
| flagZ | output | 1 | Zero flag of the result |
| carryOut | output | 1 | Captured carry flag |
| ovfOut | output | 1 | Captured overflow flag |
| arrayCycles | output | 3 | Number of cycles the last operation took |

## Verification
The sweep crosses multipliers on each side of every early-stop boundary with multiplicands that stress the sign and the zero result. Examples are 255/256, -256/-257, 65535/65536 and the extremes of the 32-bit range, paired with multiplicands such as 0, 1, -1 and 0x80000000. Three kinds of fault show up here. A count that tests one byte too many or too few gives the wrong `arrayCycles` and a `done` that arrives a cycle off. A wrong correction for all-ones upper bits gives a wrong product for small negative multipliers, though positive ones still pass. Flags taken from the accumulator before the last step give the wrong N or Z. Stray `start` pulses during a run, and operand changes right after acceptance, expose a design that recaptures its inputs.

// File: rtl/iter_mul_pkg.sv
package iter_mul_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mulState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // capture operands, clear accumulator
    logic step;  // consume one multiplier digit
    logic last;  // final digit: apply sign correction, update flags
  } mulCtl_t;

endpackage

// File: rtl/iter_mul_datapath.sv
module iter_mul_datapath
  import iter_mul_pkg::*;
#(
  parameter int W     = 32,
  parameter int DIGIT = 8,
  parameter int STEPS = W / DIGIT,
  parameter int CW    = $clog2(STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mulCtl_t       ctl,
  input  logic [W-1:0]  multiplicandIn,
  input  logic [W-1:0]  multiplierIn,
  input  logic          carryIn,
  input  logic          ovfIn,
  output logic [CW-1:0] stepsNeeded,
  output logic [W-1:0]  product,
  output logic          flagN,
  output logic          flagZ,
  output logic          carryOut,
  output logic          ovfOut,
  output logic [CW-1:0] arrayCycles
);

  logic [W-1:0]     mcand;
  logic [W-1:0]     mplier;
  logic             fillOnes;
  logic [W-1:0]     acc;
  logic [W-1:0]     magnitude;
  logic [DIGIT-1:0] digit;
  logic [W-1:0]     partial;
  logic [W-1:0]     correction;
  logic [W-1:0]     accNext;

  // cycle count: smallest k whose upper bits are pure sign fill
  always_comb begin
    magnitude   = multiplierIn[W-1] ? ~multiplierIn : multiplierIn;
    stepsNeeded = CW'(STEPS);
    for (int k = STEPS - 1; k >= 1; k--) begin
      if ((magnitude >> (DIGIT * k)) == '0) stepsNeeded = CW'(k);
    end
  end

  // one digit per cycle; the last digit carries the sign fill as weight -2^DIGIT
  always_comb begin
    digit      = mplier[DIGIT-1:0];
    partial    = W'(mcand * W'(digit));
    correction = (ctl.last && fillOnes) ? (mcand << DIGIT) : '0;
    accNext    = acc + partial - correction;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcand       <= '0;
      mplier      <= '0;
      fillOnes    <= 1'b0;
      acc         <= '0;
      flagN       <= 1'b0;
      flagZ       <= 1'b0;
      carryOut    <= 1'b0;
      ovfOut      <= 1'b0;
      arrayCycles <= '0;
    end else if (ctl.load) begin
      mcand       <= multiplicandIn;
      mplier      <= multiplierIn;
      fillOnes    <= multiplierIn[W-1];
      acc         <= '0;
      carryOut    <= carryIn;
      ovfOut      <= ovfIn;
      arrayCycles <= stepsNeeded;
    end else if (ctl.step) begin
      acc    <= accNext;
      mcand  <= mcand << DIGIT;
      mplier <= mplier >> DIGIT;
      if (ctl.last) begin
        flagN <= accNext[W-1];
        flagZ <= (accNext == '0);
      end
    end
  end

  assign product = acc;

endmodule

// File: rtl/iter_mul_ctrl.sv
module iter_mul_ctrl
  import iter_mul_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] stepsNeeded,
  output mulCtl_t       ctl,
  output logic          busy,
  output logic          done
);

  mulState_t     state;
  logic [CW-1:0] remaining;

  always_comb begin
    ctl.load = (state == ST_IDLE) && start;
    ctl.step = (state == ST_RUN);
    ctl.last = (state == ST_RUN) && (remaining == CW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      remaining <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ctl.load) begin
        state     <= ST_RUN;
        remaining <= stepsNeeded;
      end else if (ctl.step) begin
        remaining <= remaining - CW'(1);
        if (ctl.last) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end

  assign busy = (state == ST_RUN);

endmodule

// File: rtl/iter_mul.sv
module iter_mul
  import iter_mul_pkg::*;
#(
  parameter int W     = 32,
  parameter int DIGIT = 8,
  localparam int STEPS = W / DIGIT,
  localparam int CW    = $clog2(STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  multiplicand,
  input  logic [W-1:0]  multiplier,
  input  logic          carryIn,
  input  logic          ovfIn,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  product,
  output logic          flagN,
  output logic          flagZ,
  output logic          carryOut,
  output logic          ovfOut,
  output logic [CW-1:0] arrayCycles
);

  mulCtl_t       ctl;
  logic [CW-1:0] stepsNeeded;

  iter_mul_ctrl #(.CW(CW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .stepsNeeded (stepsNeeded),
    .ctl         (ctl),
    .busy        (busy),
    .done        (done)
  );

  iter_mul_datapath #(.W(W), .DIGIT(DIGIT), .STEPS(STEPS), .CW(CW)) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl            (ctl),
    .multiplicandIn (multiplicand),
    .multiplierIn   (multiplier),
    .carryIn        (carryIn),
    .ovfIn          (ovfIn),
    .stepsNeeded    (stepsNeeded),
    .product        (product),
    .flagN          (flagN),
    .flagZ          (flagZ),
    .carryOut       (carryOut),
    .ovfOut         (ovfOut),
    .arrayCycles    (arrayCycles)
  );

endmodule

// File: rtl/iter_mul_checker.sv
module iter_mul_checker #(
  parameter int W     = 32,
  parameter int STEPS = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          carryIn,
  input logic          ovfIn,
  input logic          busy,
  input logic          done,
  input logic [W-1:0]  product,
  input logic          flagN,
  input logic          flagZ,
  input logic          carryOut,
  input logic          ovfOut,
  input logic [CW-1:0] arrayCycles
);

  logic [7:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              busyCnt <= '0;
    else if (start && !busy) busyCnt <= '0;
    else if (busy)           busyCnt <= busyCnt + 8'd1;
  end

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (arrayCycles >= CW'(1) && arrayCycles <= CW'(STEPS)));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  a_r4_done_after_m: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busyCnt == 8'(arrayCycles)));

  a_r6_flags_match: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flagN == product[W-1] && flagZ == (product == '0)));

  a_r7_flags_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (carryOut == $past(carryIn) && ovfOut == $past(ovfIn)));

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> ($stable(arrayCycles) && $stable(carryOut) && $stable(ovfOut)));

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(product) && $stable(flagN) && $stable(flagZ)));

endmodule

bind iter_mul iter_mul_checker #(.W(W), .STEPS(STEPS), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .carryIn     (carryIn),
  .ovfIn       (ovfIn),
  .busy        (busy),
  .done        (done),
  .product     (product),
  .flagN       (flagN),
  .flagZ       (flagZ),
  .carryOut    (carryOut),
  .ovfOut      (ovfOut),
  .arrayCycles (arrayCycles)
);

// File: tb/iter_mul_bench.sv
`timescale 1ns/1ps
module iter_mul_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] multiplicand = '0;
  logic [31:0] multiplier = '0;
  logic        carryIn = 1'b0;
  logic        ovfIn = 1'b0;
  logic        busy, done, flagN, flagZ, carryOut, ovfOut;
  logic [31:0] product;
  logic [2:0]  arrayCycles;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;  // 50 MHz

  iter_mul u_iter_mul (
    .clk(clk), .rst_n(rst_n), .start(start),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .carryIn(carryIn), .ovfIn(ovfIn),
    .busy(busy), .done(done), .product(product),
    .flagN(flagN), .flagZ(flagZ), .carryOut(carryOut), .ovfOut(ovfOut),
    .arrayCycles(arrayCycles)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // signed-range formulation of the cycle-count rule
  function automatic int expSteps(input logic [31:0] b);
    longint s;
    s = longint'($signed(b));
    if (s >= -256 && s <= 255) return 1;
    if (s >= -65536 && s <= 65535) return 2;
    if (s >= -(64'sd1 << 24) && s <= (64'sd1 << 24) - 1) return 3;
    return 4;
  endfunction

  task automatic runOne(input logic [31:0] a, input logic [31:0] b,
                        input logic c, input logic v, input bit poke);
    logic [31:0] expP;
    int m;
    int seen;
    expP = a * b;
    m = expSteps(b);
    @(negedge clk);
    multiplicand = a; multiplier = b; carryIn = c; ovfIn = v; start = 1'b1;
    @(negedge clk);
    // scramble inputs after acceptance; optional stray start while busy
    multiplicand = ~a; multiplier = b ^ 32'h5A5A_0F0F; carryIn = ~c; ovfIn = ~v;
    start = poke;
    check(busy == 1'b1, "R2 busy after start", {31'd0, busy}, 32'd1);
    seen = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (done) begin seen = k; break; end
    end
    check(seen == m, poke ? "R8 done timing with stray start" : "R4 done timing",
          32'(seen), 32'(m));
    check(busy == 1'b0, "R4 busy low at done", {31'd0, busy}, 32'd0);
    check(arrayCycles == 3'(m), "R3 cycle count", {29'd0, arrayCycles}, 32'(m));
    check(product == expP, poke ? "R8 product unaffected" : "R5 product", product, expP);
    check(flagN == expP[31], "R6 N flag", {31'd0, flagN}, {31'd0, expP[31]});
    check(flagZ == (expP == 0), "R6 Z flag", {31'd0, flagZ}, {31'd0, expP == 0});
    check(carryOut == c && ovfOut == v, "R7 C/V passthrough",
          {30'd0, carryOut, ovfOut}, {30'd0, c, v});
    @(negedge clk);
    check(!done && product == expP && arrayCycles == 3'(m), "R9 hold after done",
          product, expP);
  endtask

  localparam logic [31:0] BLIST [18] = '{
    32'h0000_0000, 32'h0000_0001, 32'h0000_00FF, 32'h0000_0100,
    32'hFFFF_FFFF, 32'hFFFF_FF00, 32'hFFFF_FEFF, 32'h0000_FF80,
    32'h0000_FFFF, 32'h0001_0000, 32'hFFFF_0000, 32'hFFFE_FFFF,
    32'h00FF_FFFF, 32'h0100_0000, 32'hFF00_0000, 32'hFEFF_FFFF,
    32'h7FFF_FFFF, 32'h8000_0000
  };
  localparam logic [31:0] ALIST [6] = '{
    32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF,
    32'h8000_0000, 32'h1234_5678, 32'h0000_0100
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done, "R1 reset handshake", {30'd0, busy, done}, 32'd0);
    check(product == 0 && arrayCycles == 0, "R1 reset product/count", product, 32'd0);
    check(!flagN && !flagZ && !carryOut && !ovfOut, "R1 reset flags",
          {28'd0, flagN, flagZ, carryOut, ovfOut}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && product == 0, "R1 after reset", product, 32'd0);

    for (int i = 0; i < 18; i++)
      for (int j = 0; j < 6; j++)
        runOne(ALIST[j], BLIST[i], 1'(i), 1'(j), (i + j) % 5 == 0);

    for (int r = 0; r < 400; r++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      case (r % 4)
        0: b = {{24{b[31]}}, b[7:0]};
        1: b = {{16{b[31]}}, b[15:0]};
        2: b = {{8{b[31]}}, b[23:0]};
        default: ;
      endcase
      runOne(a, b, 1'(r), 1'(r >> 1), r % 7 == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule